// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block steps a processor core through its clock-control power states: Normal, AutoHALT, Stop-Grant, HALT/Grant Snoop and Sleep. A stop-clock request starts an acknowledge handshake. The block raises an acknowledge request, and the bus answers with a response-phase strobe. A fixed number of bus clocks after that strobe, the block reports Stop-Grant. From Stop-Grant the core can drop into Sleep, service snoops, absorb a bus-initialize or a reset pulse, or return to Normal once every logical processor is granted. The logical processors are reduced here to a single all-granted input.

Interrupt-type events and bus-initialize are held as one pending flag each. They are offered for service only in Normal. A one-cycle service acknowledge clears them there. Misuse of the stop-clock and sleep requests raises sticky violation flags. A snoop during Sleep, or in the cycle that enters Sleep, raises a sticky error flag.

Top module: `lps_ctrl`

## Requirements
- R1: After reset the state code is Normal and `ack_req`, `pend`, `svc_pend` and all three flags are low. The state codes are Normal=0, AutoHALT=1, Stop-Grant=3, Snoop=4 and Sleep=5.
- R2: In Normal with `halt_ind` low, a high `stpclk_req` raises `ack_req` after one edge. `ack_req` stays high until `ack_resp` is sampled. The state code becomes 3 exactly ENTRY_DLY (20) clock edges after the edge that sampled `ack_resp`, and stays 0 before that.
- R3: Dropping `stpclk_req` during the handshake has three effects: it cancels the handshake, it lowers `ack_req`, and it sets sticky `viol_early`. Dropping `stpclk_req` in Stop-Grant while `all_granted` and `bus_init` are both low also sets `viol_early`, and the block stays in Stop-Grant.
- R4: In Stop-Grant, a low `stpclk_req` with `all_granted` high moves the block to Normal on the next edge.
- R5: A `bus_init` pulse in Stop-Grant keeps the block in Stop-Grant if `stpclk_req` is high. If `stpclk_req` is low, the block moves to Normal whatever the state of `all_granted`.
- R6: A `core_rst` pulse in Stop-Grant clears all pending flags and leaves the block in Stop-Grant. In any other state it moves the block to Normal.
- R7: A high `snoop_act` in Stop-Grant or in AutoHALT moves the block to Snoop (4). The block stays there while `snoop_act` is high and then returns to the state it came from.
- R8: Sleep is entered only from Stop-Grant, by a high `slp_req`, and `slp_req` is ignored in Normal and in AutoHALT. Sleep returns to Stop-Grant once `slp_req` is low.
- R9: A low `stpclk_req` in a cycle spent in Sleep sets sticky `viol_sleep`.
- R10: An event pulse sets its bit in `pend`. The bit order is [0]=SMI, [1]=INIT, [2]=bus-initialize, [3]=LINT0 and [4]=LINT1, and repeated pulses leave a single set bit. `svc_pend` equals `pend` only in Normal and is zero elsewhere. `svc_ack` clears `pend` only in Normal and has no effect in other states.
- R11: A high `snoop_act` in Sleep, or in the Stop-Grant cycle that sees `slp_req` high, sets sticky `snoop_err`. In that second case the block still enters Sleep.
- R12: In Normal, with no stop-clock request or handshake, a high `halt_ind` moves the block to AutoHALT. AutoHALT returns to Normal when `halt_ind` falls or when any pending flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| stpclk_req | input | 1 | Stop-clock request |
| slp_req | input | 1 | Sleep request |
| bus_init | input | 1 | Bus-initialize pulse (completes in its cycle) |
| core_rst | input | 1 | Core reset pulse |
| snoop_act | input | 1 | Snoop in progress on the bus |
| halt_ind | input | 1 | Core has executed a halt |
| evt_smi | input | 1 | SMI event pulse |
| evt_init | input | 1 | INIT event pulse |
| evt_lint0 | input | 1 | LINT0 event pulse |
| evt_lint1 | input | 1 | LINT1 event pulse |
| all_granted | input | 1 | Every logical processor reports granted |
| ack_resp | input | 1 | Response phase of the acknowledge cycle |
| svc_ack | input | 1 | Pending events serviced (one cycle) |
| state_code | output | 3 | Current power state code |
| ack_req | output | 1 | Request to issue the stop-grant acknowledge cycle |
| pend | output | 5 | Latched pending events |
| svc_pend | output | 5 | Pending events offered for service |
| viol_early | output | 1 | Sticky: stop-clock released too early |
| viol_sleep | output | 1 | Sticky: stop-clock released in Sleep |
| snoop_err | output | 1 | Sticky: snoop around Sleep |

## Verification
Two functions collide in Stop-Grant when a snoop and a sleep request arrive in the same cycle. The snoop-return path and the sleep-entry path then compete for the next state. The bench raises `snoop_act` and `slp_req` together on one edge. It expects the state to become Sleep and `snoop_err` to go high, where a design that let the snoop win would go to Snoop instead. A second collision is an event pulse in AutoHALT: the pending bit is set on that edge and the exit to Normal follows one edge later, and the bench samples both of those cycles.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_AHALT   = 3'd1,
    ST_STOPGNT = 3'd3,
    ST_SNOOP   = 3'd4,
    ST_SLEEP   = 3'd5
  } pstate_e;

  typedef enum logic [1:0] {
    HS_IDLE = 2'd0,
    HS_ACK  = 2'd1,
    HS_WAIT = 2'd2
  } hs_e;

  localparam int unsigned NUM_EVT  = 5;
  localparam int unsigned EV_SMI   = 0;
  localparam int unsigned EV_INIT  = 1;
  localparam int unsigned EV_BINIT = 2;
  localparam int unsigned EV_LINT0 = 3;
  localparam int unsigned EV_LINT1 = 4;

  // Counter value loaded on the response edge so that the state changes
  // exactly dly edges after it.
  function automatic int unsigned dly_load(input int unsigned dly);
    return (dly == 0) ? 0 : dly - 1;
  endfunction

endpackage

// File: rtl/lps_entry_timer.sv
module lps_entry_timer
  import lps_pkg::*;
#(
  parameter int unsigned ENTRY_DLY = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic ack_resp,
  output logic ack_req,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(ENTRY_DLY + 1);

  hs_e           ph;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= HS_IDLE;
      cnt <= '0;
    end else begin
      case (ph)
        HS_IDLE: if (start && !abort) ph <= HS_ACK;
        HS_ACK: begin
          if (abort) ph <= HS_IDLE;
          else if (ack_resp) begin
            ph  <= HS_WAIT;
            cnt <= CW'(dly_load(ENTRY_DLY));
          end
        end
        HS_WAIT: begin
          if (abort || cnt == '0) ph <= HS_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: ph <= HS_IDLE;
      endcase
    end
  end

  assign ack_req = (ph == HS_ACK);
  assign busy    = (ph != HS_IDLE);
  assign done    = (ph == HS_WAIT) && (cnt == '0) && !abort;
endmodule

// File: rtl/lps_event_bank.sv
module lps_event_bank #(
  parameter int unsigned N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_in,
  input  logic         clr,
  input  logic         wipe,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_evt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         pend[i] <= 1'b0;
      else if (evt_in[i]) pend[i] <= 1'b1;
      else if (clr || wipe) pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/lps_fsm.sv
module lps_fsm
  import lps_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    stpclk,
  input  logic    slp,
  input  logic    binit,
  input  logic    core_rst,
  input  logic    snoop,
  input  logic    halt,
  input  logic    granted,
  input  logic    any_pend,
  input  logic    hs_busy,
  input  logic    hs_done,
  output pstate_e st,
  output logic    ret_sg,
  output logic    hs_start,
  output logic    hs_abort,
  output logic    viol_early,
  output logic    viol_sleep,
  output logic    snoop_err
);
  pstate_e nxt;
  logic    nxt_ret;
  logic    sg_release;
  logic    early_ev, sleep_ev, snperr_ev;

  assign sg_release = !stpclk && (granted || binit);

  always_comb begin
    nxt     = st;
    nxt_ret = ret_sg;
    if (core_rst && st != ST_STOPGNT) begin
      nxt = ST_NORMAL;
    end else begin
      case (st)
        ST_NORMAL: begin
          if (hs_done) nxt = ST_STOPGNT;
          else if (halt && !hs_busy && !stpclk) nxt = ST_AHALT;
        end
        ST_AHALT: begin
          if (snoop) begin
            nxt     = ST_SNOOP;
            nxt_ret = 1'b0;
          end else if (!halt || any_pend) nxt = ST_NORMAL;
        end
        ST_STOPGNT: begin
          if (core_rst) nxt = ST_STOPGNT;
          else if (sg_release) nxt = ST_NORMAL;
          else if (slp) nxt = ST_SLEEP;
          else if (snoop) begin
            nxt     = ST_SNOOP;
            nxt_ret = 1'b1;
          end
        end
        ST_SNOOP: if (!snoop) nxt = ret_sg ? ST_STOPGNT : ST_AHALT;
        ST_SLEEP: if (!slp) nxt = ST_STOPGNT;
        default:  nxt = ST_NORMAL;
      endcase
    end
  end

  assign hs_start  = (st == ST_NORMAL) && stpclk && !core_rst;
  assign hs_abort  = !stpclk || core_rst;
  assign early_ev  = (hs_busy && !stpclk) ||
                     ((st == ST_STOPGNT) && !stpclk && !granted && !binit && !core_rst);
  assign sleep_ev  = (st == ST_SLEEP) && !stpclk;
  assign snperr_ev = snoop && ((st == ST_SLEEP) || ((st == ST_STOPGNT) && slp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_NORMAL;
      ret_sg     <= 1'b0;
      viol_early <= 1'b0;
      viol_sleep <= 1'b0;
      snoop_err  <= 1'b0;
    end else begin
      st         <= nxt;
      ret_sg     <= nxt_ret;
      viol_early <= viol_early | early_ev;
      viol_sleep <= viol_sleep | sleep_ev;
      snoop_err  <= snoop_err | snperr_ev;
    end
  end
endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
  import lps_pkg::*;
#(
  parameter int unsigned ENTRY_DLY = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stpclk_req,
  input  logic                 slp_req,
  input  logic                 bus_init,
  input  logic                 core_rst,
  input  logic                 snoop_act,
  input  logic                 halt_ind,
  input  logic                 evt_smi,
  input  logic                 evt_init,
  input  logic                 evt_lint0,
  input  logic                 evt_lint1,
  input  logic                 all_granted,
  input  logic                 ack_resp,
  input  logic                 svc_ack,
  output logic [2:0]           state_code,
  output logic                 ack_req,
  output logic [NUM_EVT-1:0]   pend,
  output logic [NUM_EVT-1:0]   svc_pend,
  output logic                 viol_early,
  output logic                 viol_sleep,
  output logic                 snoop_err
);
  // Named internal events, visible to the bound checker.
  pstate_e            st_w;
  logic               ret_sg_w;
  logic               hs_start_w, hs_abort_w, hs_busy_w, hs_done_w;
  logic               in_normal_w;
  logic [NUM_EVT-1:0] evt_vec_w;

  assign in_normal_w = (st_w == ST_NORMAL);

  always_comb begin
    evt_vec_w           = '0;
    evt_vec_w[EV_SMI]   = evt_smi;
    evt_vec_w[EV_INIT]  = evt_init;
    evt_vec_w[EV_BINIT] = bus_init;
    evt_vec_w[EV_LINT0] = evt_lint0;
    evt_vec_w[EV_LINT1] = evt_lint1;
  end

  lps_entry_timer #(.ENTRY_DLY(ENTRY_DLY)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (hs_start_w),
    .abort    (hs_abort_w),
    .ack_resp (ack_resp),
    .ack_req  (ack_req),
    .busy     (hs_busy_w),
    .done     (hs_done_w)
  );

  lps_event_bank #(.N(NUM_EVT)) u_events (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt_in (evt_vec_w),
    .clr    (svc_ack && in_normal_w),
    .wipe   (core_rst),
    .pend   (pend)
  );

  lps_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .stpclk     (stpclk_req),
    .slp        (slp_req),
    .binit      (bus_init),
    .core_rst   (core_rst),
    .snoop      (snoop_act),
    .halt       (halt_ind),
    .granted    (all_granted),
    .any_pend   (|pend),
    .hs_busy    (hs_busy_w),
    .hs_done    (hs_done_w),
    .st         (st_w),
    .ret_sg     (ret_sg_w),
    .hs_start   (hs_start_w),
    .hs_abort   (hs_abort_w),
    .viol_early (viol_early),
    .viol_sleep (viol_sleep),
    .snoop_err  (snoop_err)
  );

  assign state_code = st_w;
  assign svc_pend   = in_normal_w ? pend : '0;
endmodule

// File: rtl/lps_ctrl_chk.sv
module lps_ctrl_chk
  import lps_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [2:0]         state_code,
  input logic               stpclk_req,
  input logic               snoop_act,
  input logic               core_rst,
  input logic               hs_busy_w,
  input logic               hs_done_w,
  input logic               ret_sg_w,
  input logic [NUM_EVT-1:0] pend,
  input logic               viol_early,
  input logic               snoop_err
);
  assert_sg_after_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_STOPGNT && $past(state_code) == ST_NORMAL) |-> $past(hs_done_w));

  assert_early_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_busy_w && !stpclk_req) |=> viol_early);

  assert_snoop_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_SNOOP && !snoop_act && !core_rst) |=>
      ((state_code == ST_STOPGNT) == $past(ret_sg_w)));

  assert_no_sleep_from_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_NORMAL || state_code == ST_AHALT) |=> state_code != ST_SLEEP);

  assert_pend_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != ST_NORMAL && !core_rst) |=> ((pend & $past(pend)) == $past(pend)));

  assert_snoop_in_sleep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == ST_SLEEP && snoop_act) |=> snoop_err);
endmodule

bind lps_ctrl lps_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state_code (state_code),
  .stpclk_req (stpclk_req),
  .snoop_act  (snoop_act),
  .core_rst   (core_rst),
  .hs_busy_w  (hs_busy_w),
  .hs_done_w  (hs_done_w),
  .ret_sg_w   (ret_sg_w),
  .pend       (pend),
  .viol_early (viol_early),
  .snoop_err  (snoop_err)
);

// File: tb/tb_lps_ctrl.sv
module tb_lps_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stpclk_req = 0, slp_req = 0, bus_init = 0, core_rst = 0, snoop_act = 0;
  logic halt_ind = 0, evt_smi = 0, evt_init = 0, evt_lint0 = 0, evt_lint1 = 0;
  logic all_granted = 1, ack_resp = 0, svc_ack = 0;
  logic [2:0] state_code;
  logic       ack_req, viol_early, viol_sleep, snoop_err;
  logic [4:0] pend, svc_pend;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lps_ctrl dut (
    .clk(clk), .rst_n(rst_n), .stpclk_req(stpclk_req), .slp_req(slp_req),
    .bus_init(bus_init), .core_rst(core_rst), .snoop_act(snoop_act),
    .halt_ind(halt_ind), .evt_smi(evt_smi), .evt_init(evt_init),
    .evt_lint0(evt_lint0), .evt_lint1(evt_lint1), .all_granted(all_granted),
    .ack_resp(ack_resp), .svc_ack(svc_ack), .state_code(state_code),
    .ack_req(ack_req), .pend(pend), .svc_pend(svc_pend),
    .viol_early(viol_early), .viol_sleep(viol_sleep), .snoop_err(snoop_err)
  );

  localparam logic [2:0] NRM = 3'd0, AHL = 3'd1, SGT = 3'd3, SNP = 3'd4, SLP = 3'd5;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic enter_sg();
    stpclk_req = 1; step(1);
    ack_resp = 1; step(1); ack_resp = 0;
    step(20);
  endtask

  task automatic t_reset();
    check("R1 state", state_code, NRM);
    check("R1 ack_req", ack_req, 0);
    check("R1 pend", pend, 0);
    check("R1 flags", {viol_early, viol_sleep, snoop_err}, 0);
  endtask

  task automatic t_sleep_ignored_normal();
    slp_req = 1; step(2);
    check("R8 sleep ignored in Normal", state_code, NRM);
    slp_req = 0;
  endtask

  task automatic t_autohalt();
    halt_ind = 1; step(1);
    check("R12 halt enters AutoHALT", state_code, AHL);
    slp_req = 1; step(1);
    check("R8 sleep ignored in AutoHALT", state_code, AHL);
    slp_req = 0;
    snoop_act = 1; step(2);
    check("R7 snoop from AutoHALT", state_code, SNP);
    snoop_act = 0; step(1);
    check("R7 return to AutoHALT", state_code, AHL);
    check("R11 no error outside sleep", snoop_err, 0);
    halt_ind = 0; step(1);
    check("R12 halt drop leaves AutoHALT", state_code, NRM);
    halt_ind = 1; step(1);
    evt_lint0 = 1; step(1); evt_lint0 = 0;
    check("R10 LINT0 latched in AutoHALT", pend, 5'b01000);
    check("R12 still AutoHALT on event edge", state_code, AHL);
    check("R10 no service outside Normal", svc_pend, 0);
    step(1); halt_ind = 0;
    check("R12 pending event wakes", state_code, NRM);
    check("R10 offered in Normal", svc_pend, 5'b01000);
    svc_ack = 1; step(1); svc_ack = 0;
    check("R10 cleared by svc_ack", pend, 0);
    halt_ind = 1; step(1);
    core_rst = 1; step(1); core_rst = 0; halt_ind = 0;
    check("R6 core reset outside Stop-Grant", state_code, NRM);
    step(1);
  endtask

  task automatic t_enter_sg();
    stpclk_req = 1; step(1);
    check("R2 ack_req raised", ack_req, 1);
    step(3);
    check("R2 ack_req held", ack_req, 1);
    ack_resp = 1; step(1); ack_resp = 0;
    check("R2 ack_req drops", ack_req, 0);
    for (int i = 1; i < 20; i++) begin
      step(1);
      check("R2 not yet Stop-Grant", state_code, NRM);
    end
    step(1);
    check("R2 Stop-Grant after delay", state_code, SGT);
  endtask

  task automatic t_snoop_sg();
    snoop_act = 1; step(1);
    check("R7 snoop from Stop-Grant", state_code, SNP);
    step(2);
    check("R7 stays in Snoop", state_code, SNP);
    snoop_act = 0; step(1);
    check("R7 return to Stop-Grant", state_code, SGT);
  endtask

  task automatic t_events_sg();
    evt_smi = 1; step(1); evt_smi = 0;
    evt_smi = 1; step(1); evt_smi = 0;
    evt_lint1 = 1; step(1); evt_lint1 = 0;
    check("R10 collapse SMI and LINT1", pend, 5'b10001);
    check("R10 no service in Stop-Grant", svc_pend, 0);
    svc_ack = 1; step(1); svc_ack = 0;
    check("R10 svc_ack ignored in Stop-Grant", pend, 5'b10001);
  endtask

  task automatic t_binit_hold();
    bus_init = 1; step(1); bus_init = 0;
    check("R5 stays Stop-Grant", state_code, SGT);
    check("R10 bus-init latched", pend, 5'b10101);
  endtask

  task automatic t_sleep_legal();
    slp_req = 1; step(2);
    check("R8 enter Sleep", state_code, SLP);
    slp_req = 0; step(1);
    check("R8 Sleep back to Stop-Grant", state_code, SGT);
    check("R9 legal order no flag", viol_sleep, 0);
  endtask

  task automatic t_release();
    stpclk_req = 0; step(1);
    check("R4 release to Normal", state_code, NRM);
    check("R3 legal release no flag", viol_early, 0);
    check("R10 offered after return", svc_pend, 5'b10101);
    svc_ack = 1; step(1); svc_ack = 0;
    check("R10 cleared in Normal", pend, 0);
  endtask

  task automatic t_reset_in_sg();
    enter_sg();
    evt_smi = 1; step(1); evt_smi = 0;
    core_rst = 1; step(1); core_rst = 0;
    check("R6 stays Stop-Grant", state_code, SGT);
    check("R6 pending wiped", pend, 0);
    stpclk_req = 0; step(1);
    check("R6 release after reset", state_code, NRM);
  endtask

  task automatic t_binit_exit();
    enter_sg();
    all_granted = 0; stpclk_req = 0; bus_init = 1; step(1);
    bus_init = 0; all_granted = 1;
    check("R5 bus-init returns Normal", state_code, NRM);
    check("R3 no flag on bus-init exit", viol_early, 0);
    svc_ack = 1; step(1); svc_ack = 0;
  endtask

  task automatic t_early();
    stpclk_req = 1; step(1);
    check("R3 handshake started", ack_req, 1);
    stpclk_req = 0; step(1);
    check("R3 handshake cancelled", ack_req, 0);
    check("R3 early flag", viol_early, 1);
    check("R3 still Normal", state_code, NRM);
    enter_sg();
    all_granted = 0; stpclk_req = 0; step(2);
    check("R3 ungranted release holds", state_code, SGT);
    all_granted = 1; step(1);
    check("R4 granted release", state_code, NRM);
  endtask

  task automatic t_sleep_viol();
    enter_sg();
    slp_req = 1; step(1);
    slp_req = 0; stpclk_req = 0; step(1);
    check("R9 sleep order flag", viol_sleep, 1);
    check("R8 back to Stop-Grant", state_code, SGT);
    step(1);
    check("R4 then Normal", state_code, NRM);
  endtask

  task automatic t_snoop_sleep();
    enter_sg();
    snoop_act = 1; slp_req = 1; step(1);
    check("R11 sleep wins over snoop", state_code, SLP);
    check("R11 snoop error on entry", snoop_err, 1);
    snoop_act = 0; slp_req = 0; step(1);
    check("R8 leave Sleep", state_code, SGT);
    stpclk_req = 0; step(1);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    t_reset();
    t_sleep_ignored_normal();
    t_autohalt();
    t_enter_sg();
    t_snoop_sg();
    t_events_sg();
    t_binit_hold();
    t_sleep_legal();
    t_release();
    t_reset_in_sg();
    t_binit_exit();
    t_early();
    t_sleep_viol();
    t_snoop_sleep();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule